// File: doc/BRIEF.md
# Non-Volatile Byte Array Program/Erase Sequencer

This block holds a small byte-wide non-volatile array in registers, plus one configuration byte stored at the index just past the last array byte. A CPU-side bus reaches three targets: the array, a one-byte sequencing control register, and the active configuration register. A write to the array only captures an address and a byte. The array changes when software raises the programming-voltage bit, holds it for a minimum number of clock cycles, and then drops it. At that point the block does one of four operations: it clears bits in one byte, erases one byte, erases a 16-byte row, or erases everything.

The configuration byte is programmed through the same sequence. The value that governs the block is a copy loaded only while reset is applied, so a new setting takes effect at the next reset. Bit 0 of the active copy decides whether the array answers the bus at all. Misuse of the sequence raises a sticky error with a cause code. A `cpu_run` input of 0 marks a debugger access: a write then lands in the array directly.

Top module: `eep_prog_ctrl`

## Requirements
- R1: The bus target is set by `bus_tgt`: 0 is the array, 1 is the control register, 2 is the configuration register, and 3 selects nothing (reads return 0xFF). The control register has five bits: bit 0 byte mode, bit 1 row mode, bit 2 erase, bit 3 latch, bit 4 voltage. Bits 7:5 read as 0.
- R2: A control write that takes both the latch bit and the voltage bit from 0 to 1 is discarded, leaving the register unchanged, and raises cause 1. Clearing both bits in one write is legal.
- R3: Setting the voltage bit raises cause 2 when the latch bit was not already set. Otherwise it raises cause 3 when no address and byte have been captured. The control write is still accepted.
- R4: With `cpu_run`=1 and the latch bit set, the first data write (array or configuration target) captures the index and byte. A second data write before the voltage bit falls raises cause 5 and is ignored. A data write with the latch bit clear raises cause 4 and is ignored. With `cpu_run`=0, a data write stores the byte directly.
- R5: An array read with `cpu_run`=1 while the latch bit is set raises cause 6.
- R6: Let N be the number of clock edges from the write that sets the voltage bit to the write that clears it. If N is below MIN_HOLD, the write raises cause 7 and the array is unchanged. If N equals MIN_HOLD, the operation completes.
- R7: When the voltage bit falls after a long enough hold with the erase bit clear, the captured byte is ANDed into the target, so bits only go from 1 to 0.
- R8: With the erase bit set, and either byte mode set or the configuration byte as the target, only the target becomes 0xFF.
- R9: With the erase bit set, row mode set, byte mode clear and an array target, the 16 bytes whose indices match the target above bit 3 become 0xFF. With the erase bit set and neither mode bit set, every array byte and the configuration byte become 0xFF.
- R10: Reset clears the control register and the capture state, and loads the active configuration from the stored configuration byte. Array contents survive reset. A programmed configuration byte is not visible on the configuration register until the next reset.
- R11: Array reads and writes take effect only when bit 0 of the active configuration is 1. Otherwise array reads return 0xFF and array writes are ignored without an error. The configuration register stays accessible either way. At power-up every cell holds 0xFF.
- R12: `err_flag` is sticky and `err_code` keeps the first cause seen. Only reset clears them (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_run | input | 1 | 1 for CPU accesses, 0 for direct debugger writes |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Single-byte write strobe |
| bus_tgt | input | 2 | Access target select |
| bus_addr | input | AW | Array byte index |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational) |
| err_flag | output | 1 | Sticky error flag |
| err_code | output | 3 | First error cause |

## Verification
The assertions check the following on every cycle: the both-bits rejection leaves the control register as it was, the error cause never changes once raised, no operation completes without the minimum hold, a capture exists only under the latch, the active configuration stays fixed between resets, and reads of a disabled array return 0xFF. Only the bench scenarios can show the array contents after each operation type. This covers the AND merge, single-byte, row and bulk erase, the configuration byte taking effect at reset, and the one-cycle boundary of the hold window.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int CTL_W     = 5;
  localparam int B_BYTE    = 0;
  localparam int B_ROW     = 1;
  localparam int B_ERASE   = 2;
  localparam int B_LATCH   = 3;
  localparam int B_HV      = 4;
  localparam int CNT_W     = 32;
  localparam int ROW_SHIFT = 4;
  localparam int EN_BIT    = 0;

  typedef enum logic [1:0] {TGT_ARR = 2'd0, TGT_CTL = 2'd1, TGT_CFG = 2'd2, TGT_NONE = 2'd3} tgt_e;
  typedef enum logic [1:0] {OP_PROG, OP_BERASE, OP_RERASE, OP_BULK} op_e;
  typedef enum logic [2:0] {
    E_NONE = 3'd0, E_BOTH = 3'd1, E_HV_NOLATCH = 3'd2, E_HV_NOADDR = 3'd3,
    E_WR_NOLATCH = 3'd4, E_WR_TWICE = 3'd5, E_RD_BUSY = 3'd6, E_SHORT = 3'd7
  } err_e;

  function automatic logic [CTL_W-1:0] fresh_rise(logic [CTL_W-1:0] prev, logic [CTL_W-1:0] nxt);
    return ~prev & nxt;
  endfunction

  function automatic op_e pick_op(logic [CTL_W-1:0] c, logic on_cfg);
    if (!c[B_ERASE])              return OP_PROG;
    else if (c[B_BYTE] || on_cfg) return OP_BERASE;
    else if (c[B_ROW])            return OP_RERASE;
    else                          return OP_BULK;
  endfunction

  function automatic logic hold_met(logic [CNT_W-1:0] now, logic [CNT_W-1:0] start, int unsigned min_c);
    return (now - start) >= min_c;
  endfunction

  function automatic logic same_row(int unsigned a, int unsigned b);
    return (a >> ROW_SHIFT) == (b >> ROW_SHIFT);
  endfunction
endpackage

// File: rtl/eep_hold_timer.sv
module eep_hold_timer
  import eep_pkg::*;
#(
  parameter int unsigned MIN_HOLD = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic hold_ok
);
  logic [CNT_W-1:0] cyc_q;
  logic [CNT_W-1:0] start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      start_q <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      if (arm) start_q <= cyc_q;
    end
  end

  assign hold_ok = hold_met(cyc_q, start_q, MIN_HOLD);
endmodule

// File: rtl/eep_seq.sv
module eep_seq
  import eep_pkg::*;
#(
  parameter int IW      = 7,
  parameter int CFG_IDX = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_run,
  input  logic             ctl_we,
  input  logic             data_we,
  input  logic             rd_arr,
  input  logic [7:0]       wdata,
  input  logic [IW-1:0]    widx,
  input  logic             hold_ok,
  output logic [CTL_W-1:0] ctl_q,
  output logic             cap_vld,
  output logic [IW-1:0]    cap_idx,
  output logic [7:0]       cap_byte,
  output logic             arm,
  output logic             commit,
  output op_e              commit_op,
  output logic             direct_we,
  output logic             err_flag,
  output logic [2:0]       err_code
);
  logic [CTL_W-1:0] newly;
  logic both_bad, ctl_ok, hv_up, hv_dn, cap_ev, short_ev;
  err_e ev, err_q;

  assign newly     = fresh_rise(ctl_q, wdata[CTL_W-1:0]);
  assign both_bad  = ctl_we && newly[B_LATCH] && newly[B_HV];
  assign ctl_ok    = ctl_we && !both_bad;
  assign hv_up     = ctl_ok && !ctl_q[B_HV] && wdata[B_HV];
  assign hv_dn     = ctl_ok && ctl_q[B_HV] && !wdata[B_HV];
  assign arm       = hv_up;
  assign short_ev  = hv_dn && !hold_ok;
  assign commit    = hv_dn && hold_ok && cap_vld;
  assign commit_op = pick_op(ctl_q, cap_idx == IW'(CFG_IDX));
  assign cap_ev    = data_we && cpu_run && ctl_q[B_LATCH] && !cap_vld;
  assign direct_we = data_we && !cpu_run && rst_n;

  always_comb begin
    if (both_bad)                                  ev = E_BOTH;
    else if (hv_up && !ctl_q[B_LATCH])             ev = E_HV_NOLATCH;
    else if (hv_up && !cap_vld)                    ev = E_HV_NOADDR;
    else if (short_ev)                             ev = E_SHORT;
    else if (data_we && cpu_run && !ctl_q[B_LATCH]) ev = E_WR_NOLATCH;
    else if (data_we && cpu_run && cap_vld)        ev = E_WR_TWICE;
    else if (rd_arr && cpu_run && ctl_q[B_LATCH])  ev = E_RD_BUSY;
    else                                           ev = E_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      cap_vld  <= 1'b0;
      cap_idx  <= '0;
      cap_byte <= '0;
      err_flag <= 1'b0;
      err_q    <= E_NONE;
    end else begin
      if (ctl_ok) ctl_q <= wdata[CTL_W-1:0];
      if (ctl_ok && (!wdata[B_LATCH] || hv_dn)) begin
        cap_vld <= 1'b0;
      end else if (cap_ev) begin
        cap_vld  <= 1'b1;
        cap_idx  <= widx;
        cap_byte <= wdata;
      end
      if (!err_flag && ev != E_NONE) begin
        err_flag <= 1'b1;
        err_q    <= ev;
      end
    end
  end

  assign err_code = err_q;
endmodule

// File: rtl/eep_store.sv
module eep_store
  import eep_pkg::*;
#(
  parameter int NB = 64,
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          commit,
  input  op_e           op,
  input  logic [IW-1:0] cap_idx,
  input  logic [7:0]    cap_byte,
  input  logic          direct_we,
  input  logic [IW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_byte,
  output logic [7:0]    cfg_byte
);
  logic [7:0] mem [0:NB];

  initial begin
    for (int i = 0; i <= NB; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i <= NB; i++) begin
      if (commit) begin
        unique case (op)
          OP_PROG:   if (IW'(i) == cap_idx) mem[i] <= mem[i] & cap_byte;
          OP_BERASE: if (IW'(i) == cap_idx) mem[i] <= 8'hFF;
          OP_RERASE: if (i < NB && same_row(i, 32'(cap_idx))) mem[i] <= 8'hFF;
          OP_BULK:   mem[i] <= 8'hFF;
          default: ;
        endcase
      end else if (direct_we && IW'(i) == widx) begin
        mem[i] <= wdata;
      end
    end
  end

  assign rd_byte  = mem[rd_idx];
  assign cfg_byte = mem[NB];
endmodule

// File: rtl/eep_prog_ctrl.sv
module eep_prog_ctrl
  import eep_pkg::*;
#(
  parameter int ARR_BYTES         = 64,
  parameter int unsigned MIN_HOLD = 10000,
  localparam int AW      = $clog2(ARR_BYTES),
  localparam int IW      = $clog2(ARR_BYTES + 1),
  localparam int CFG_IDX = ARR_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_run,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [1:0]    bus_tgt,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          err_flag,
  output logic [2:0]    err_code
);
  logic sel_arr, sel_ctl, sel_cfg, arr_on;
  logic ctl_we, data_we, rd_arr;
  logic [IW-1:0] widx, rd_idx, cap_idx;
  logic [CTL_W-1:0] ctl_q;
  logic cap_vld, arm, commit, direct_we, hold_ok;
  logic [7:0] cap_byte, rd_byte, cfg_byte, cfg_act;
  op_e commit_op;

  assign sel_arr = bus_tgt == TGT_ARR;
  assign sel_ctl = bus_tgt == TGT_CTL;
  assign sel_cfg = bus_tgt == TGT_CFG;
  assign arr_on  = cfg_act[EN_BIT];
  assign ctl_we  = bus_wr && sel_ctl;
  assign data_we = bus_wr && ((sel_arr && arr_on) || sel_cfg);
  assign rd_arr  = bus_rd && sel_arr && arr_on;
  assign widx    = sel_cfg ? IW'(CFG_IDX) : IW'(bus_addr);
  assign rd_idx  = IW'(bus_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_act <= cfg_byte;
  end

  always_comb begin
    if (sel_ctl)                bus_rdata = {{(8-CTL_W){1'b0}}, ctl_q};
    else if (sel_cfg)           bus_rdata = cfg_act;
    else if (sel_arr && arr_on) bus_rdata = rd_byte;
    else                        bus_rdata = 8'hFF;
  end

  eep_hold_timer #(.MIN_HOLD(MIN_HOLD)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(arm), .hold_ok(hold_ok)
  );

  eep_seq #(.IW(IW), .CFG_IDX(CFG_IDX)) u_seq (
    .clk(clk), .rst_n(rst_n), .cpu_run(cpu_run), .ctl_we(ctl_we),
    .data_we(data_we), .rd_arr(rd_arr), .wdata(bus_wdata), .widx(widx),
    .hold_ok(hold_ok), .ctl_q(ctl_q), .cap_vld(cap_vld), .cap_idx(cap_idx),
    .cap_byte(cap_byte), .arm(arm), .commit(commit), .commit_op(commit_op),
    .direct_we(direct_we), .err_flag(err_flag), .err_code(err_code)
  );

  eep_store #(.NB(ARR_BYTES), .IW(IW)) u_store (
    .clk(clk), .commit(commit), .op(commit_op), .cap_idx(cap_idx),
    .cap_byte(cap_byte), .direct_we(direct_we), .widx(widx),
    .wdata(bus_wdata), .rd_idx(rd_idx), .rd_byte(rd_byte), .cfg_byte(cfg_byte)
  );
endmodule

// File: rtl/eep_prog_ctrl_chk.sv
module eep_prog_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [1:0] bus_tgt,
  input logic       wr_latch,
  input logic       wr_hv,
  input logic [7:0] bus_rdata,
  input logic       err_flag,
  input logic [2:0] err_code,
  input logic [4:0] ctl_q,
  input logic       cap_vld,
  input logic       commit,
  input logic       hold_ok,
  input logic [7:0] cfg_act
);
  a_r2_both_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_tgt == 2'd1 && !ctl_q[3] && !ctl_q[4] && wr_latch && wr_hv)
      |=> ($stable(ctl_q) && err_flag));

  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> (err_flag && $stable(err_code)));

  a_r6_commit_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> hold_ok);

  a_r4_capture_under_latch: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld |-> ctl_q[3]);

  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(cfg_act));

  a_r11_disabled_reads_erased: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_tgt == 2'd0 && !cfg_act[0]) |-> bus_rdata == 8'hFF);

  a_r1_ctl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_tgt == 2'd1) |-> bus_rdata[7:5] == 3'd0);
endmodule

bind eep_prog_ctrl eep_prog_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_tgt(bus_tgt),
  .wr_latch(bus_wdata[3]), .wr_hv(bus_wdata[4]), .bus_rdata(bus_rdata),
  .err_flag(err_flag), .err_code(err_code), .ctl_q(ctl_q), .cap_vld(cap_vld),
  .commit(commit), .hold_ok(hold_ok), .cfg_act(cfg_act)
);

// File: tb/tb_eep_prog_ctrl.sv
`timescale 1ns/1ps
module tb_eep_prog_ctrl;
  localparam int NB = 32;
  localparam int HOLD = 20;
  localparam logic [1:0] T_ARR = 2'd0, T_CTL = 2'd1, T_CFG = 2'd2;
  localparam logic [7:0] C_BYTE = 8'h01, C_ROW = 8'h02, C_ERASE = 8'h04, C_LATCH = 8'h08, C_HV = 8'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_run = 1'b1;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_tgt = 2'd0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic err_flag;
  logic [2:0] err_code;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mdl [0:NB];
  logic [7:0] v;

  always #10 clk = ~clk;

  eep_prog_ctrl #(.ARR_BYTES(NB), .MIN_HOLD(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_run(cpu_run), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_tgt(bus_tgt), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .err_flag(err_flag), .err_code(err_code)
  );

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    report();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_wr(input logic [1:0] t, input int a, input logic [7:0] d);
    bus_tgt = t; bus_addr = a[4:0]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] t, input int a, output logic [7:0] d);
    bus_tgt = t; bus_addr = a[4:0]; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
  endtask

  task automatic run_op(input logic [7:0] m, input logic [1:0] t, input int a,
                        input logic [7:0] d, input int hold_idle);
    do_wr(T_CTL, 0, C_LATCH | m);
    do_wr(t, a, d);
    do_wr(T_CTL, 0, C_LATCH | C_HV | m);
    idle(hold_idle);
    do_wr(T_CTL, 0, C_LATCH | m);
    do_wr(T_CTL, 0, 8'h00);
  endtask

  task automatic cmp_all(input string req);
    logic [7:0] r;
    for (int i = 0; i < NB; i++) begin
      do_rd(T_ARR, i, r);
      chk(req, r, mdl[i]);
    end
  endtask

  task automatic load_pattern();
    cpu_run = 1'b0;
    for (int i = 0; i < NB; i++) begin
      do_wr(T_ARR, i, 8'((i * 37 + 5) & 255));
      mdl[i] = 8'((i * 37 + 5) & 255);
    end
    cpu_run = 1'b1;
  endtask

  task automatic chk_err(input string req, input logic f, input logic [2:0] c);
    chk(req, err_flag, f);
    chk(req, err_code, c);
  endtask

  initial begin
    for (int i = 0; i <= NB; i++) mdl[i] = 8'hFF;
    @(negedge clk);
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R10 reset state, R11 erased at power-up and enabled
    do_rd(T_CTL, 0, v); chk("R10 ctl after reset", v, 8'h00);
    do_rd(T_CFG, 0, v); chk("R10 cfg after reset", v, 8'hFF);
    chk_err("R12 no error after reset", 1'b0, 3'd0);
    cmp_all("R11 erased at power-up");

    // R4 direct debugger writes
    load_pattern();
    cmp_all("R4 direct write");

    // R1 control readback
    do_wr(T_CTL, 0, 8'hE7);
    do_rd(T_CTL, 0, v); chk("R1 ctl upper bits zero", v, 8'h07);
    do_wr(T_CTL, 0, 8'h00);
    do_rd(T_CTL, 0, v); chk("R1 ctl cleared", v, 8'h00);

    // R7 program (AND merge), hold exactly MIN_HOLD (R6 boundary)
    run_op(C_BYTE, T_ARR, 0, 8'hF0, HOLD - 1);  mdl[0]  = mdl[0]  & 8'hF0;
    run_op(8'h00,  T_ARR, 5, 8'h3C, HOLD - 1);  mdl[5]  = mdl[5]  & 8'h3C;
    run_op(C_ROW,  T_ARR, 16, 8'h0F, HOLD - 1); mdl[16] = mdl[16] & 8'h0F;
    run_op(8'h00,  T_ARR, 31, 8'hAA, HOLD - 1); mdl[31] = mdl[31] & 8'hAA;
    cmp_all("R7 program AND");
    chk_err("R6 hold equal to minimum accepted", 1'b0, 3'd0);

    // R8 byte erase
    run_op(C_ERASE | C_BYTE, T_ARR, 9, 8'h00, HOLD - 1); mdl[9] = 8'hFF;
    cmp_all("R8 byte erase");

    // R9 row erase
    run_op(C_ERASE | C_ROW, T_ARR, 21, 8'h00, HOLD - 1);
    for (int i = 16; i < 32; i++) mdl[i] = 8'hFF;
    cmp_all("R9 row erase upper");
    run_op(C_ERASE | C_ROW, T_ARR, 3, 8'h00, HOLD - 1);
    for (int i = 0; i < 16; i++) mdl[i] = 8'hFF;
    cmp_all("R9 row erase lower");

    // R6 short hold
    load_pattern();
    run_op(8'h00, T_ARR, 2, 8'h00, HOLD - 2);
    chk_err("R6 short hold cause 7", 1'b1, 3'd7);
    cmp_all("R6 short hold array unchanged");
    do_reset();
    chk_err("R12 reset clears error", 1'b0, 3'd0);

    // R10 configuration takes effect at reset; array persists
    run_op(8'h00, T_CFG, 0, 8'hFD, HOLD - 1);
    do_rd(T_CFG, 0, v); chk("R10 cfg not yet active", v, 8'hFF);
    do_reset();
    do_rd(T_CFG, 0, v); chk("R10 cfg active after reset", v, 8'hFD);
    cmp_all("R10 array persists over reset");

    // R8 erase with cfg target is single-byte even in row mode
    run_op(C_ERASE | C_ROW, T_CFG, 0, 8'h00, HOLD - 1);
    cmp_all("R8 cfg erase leaves array");
    do_reset();
    do_rd(T_CFG, 0, v); chk("R8 cfg erased", v, 8'hFF);

    // R9 bulk erase includes cfg
    run_op(8'h00, T_CFG, 0, 8'hFD, HOLD - 1);
    run_op(C_ERASE, T_ARR, 7, 8'h00, HOLD - 1);
    for (int i = 0; i <= NB; i++) mdl[i] = 8'hFF;
    cmp_all("R9 bulk erase array");
    do_reset();
    do_rd(T_CFG, 0, v); chk("R9 bulk erase cfg", v, 8'hFF);

    // R2 both bits rising rejected
    do_wr(T_CTL, 0, C_LATCH | C_HV);
    chk_err("R2 both rising cause 1", 1'b1, 3'd1);
    do_rd(T_CTL, 0, v); chk("R2 ctl unchanged", v, 8'h00);
    do_reset();
    do_wr(T_CTL, 0, C_LATCH);
    do_wr(T_ARR, 4, 8'h7E);
    do_wr(T_CTL, 0, C_LATCH | C_HV);
    idle(HOLD - 1);
    do_wr(T_CTL, 0, 8'h00); mdl[4] = 8'h7E;
    chk_err("R2 clearing both legal", 1'b0, 3'd0);
    cmp_all("R2 clear-both commits");

    // R3 voltage without latch / without capture
    do_wr(T_CTL, 0, C_HV);
    chk_err("R3 hv without latch cause 2", 1'b1, 3'd2);
    do_rd(T_CTL, 0, v); chk("R3 ctl accepted", v, 8'h10);
    do_reset();
    do_wr(T_CTL, 0, C_LATCH);
    do_wr(T_CTL, 0, C_LATCH | C_HV);
    chk_err("R3 hv without capture cause 3", 1'b1, 3'd3);
    do_reset();

    // R4 second write ignored
    do_wr(T_CTL, 0, C_LATCH);
    do_wr(T_ARR, 10, 8'h0F);
    do_wr(T_ARR, 11, 8'h00);
    chk_err("R4 second data write cause 5", 1'b1, 3'd5);
    do_wr(T_CTL, 0, C_LATCH | C_HV);
    idle(HOLD - 1);
    do_wr(T_CTL, 0, C_LATCH);
    do_wr(T_CTL, 0, 8'h00);
    mdl[10] = 8'h0F;
    cmp_all("R4 first capture kept");
    do_reset();

    // R4 write without latch; R12 first cause kept
    do_wr(T_ARR, 12, 8'h00);
    chk_err("R4 write without latch cause 4", 1'b1, 3'd4);
    cmp_all("R4 unlatched write ignored");
    do_wr(T_CTL, 0, C_LATCH);
    do_rd(T_ARR, 0, v);
    chk_err("R12 first cause kept", 1'b1, 3'd4);
    do_reset();

    // R5 read while latched
    do_wr(T_CTL, 0, C_LATCH);
    do_rd(T_ARR, 0, v);
    chk_err("R5 read while latched cause 6", 1'b1, 3'd6);
    do_reset();

    // R11 disabled array
    run_op(8'h00, T_CFG, 0, 8'hFE, HOLD - 1);
    do_reset();
    do_rd(T_CFG, 0, v); chk("R11 cfg accessible", v, 8'hFE);
    do_rd(T_ARR, 10, v); chk("R11 disabled read erased", v, 8'hFF);
    cpu_run = 1'b0; do_wr(T_ARR, 10, 8'h55); cpu_run = 1'b1;
    do_rd(T_ARR, 10, v); chk("R11 disabled read after write", v, 8'hFF);
    do_wr(T_CTL, 0, C_LATCH);
    do_wr(T_ARR, 3, 8'h00);
    do_wr(T_CTL, 0, 8'h00);
    chk_err("R11 disabled write no error", 1'b0, 3'd0);
    run_op(C_ERASE | C_BYTE, T_CFG, 0, 8'h00, HOLD - 1);
    do_reset();
    do_rd(T_CFG, 0, v); chk("R11 re-enabled cfg", v, 8'hFF);
    cmp_all("R11 disabled writes ignored");
    chk_err("R12 clean end", 1'b0, 3'd0);

    report();
  end
endmodule